// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a range of bytes into a parallel UV-erasable or one-time-programmable memory and then confirms the result. A single start command supplies the first and last address. The sequencer raises the program supply and the core supply to their programming levels. For each address it fetches the target byte from a byte-source port that answers combinationally to the requested address, drives it onto the memory data pins, and fires a 100 us chip-enable pulse. It then turns the bus around and reads the byte back with output enable. When the read-back matches, the sequencer moves straight to the next address. When it does not match, the pulse is repeated. A byte that still mismatches after 25 pulses stops the run.

When the last byte has been written, the program supply is dropped. The whole range is then read back twice in ascending order, first with the supply selector at the raised check level and then at the lowered one. A mismatch in either pass stops the run and reports the address. A clean finish gives a one-cycle done pulse. All pulse, setup, hold and turnaround times are cycle counts computed from a clock-frequency parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is applied and afterwards until a start, the outputs rest at: chip enable and output enable high (inactive), data drive off, program supply off, supply select 00 (nominal), done 0, fail 0, busy 0.
- R2: From an accepted start until the last byte is verified, the program supply is on and supply select is 01 (programming level). Every program pulse occurs under these conditions.
- R3: Each program pulse holds chip enable low for exactly CLK_HZ/10000 cycles (100 us, inside the 95 to 105 us window), with output enable high and the target byte driven.
- R4: The address and the driven byte are stable at least 2 us before chip enable falls. They stay driven at least 2 us after it rises. Output enable falls no sooner than 2 us after the data drive is released, and is never low while the data drive is on.
- R5: A verify read uses chip enable high and output enable low, and compares the read-back with the source byte for the current address. On a match, no further pulse is applied to that address and the next address follows at once, so each byte receives exactly as many pulses as it needs.
- R6: The pulse counter restarts for each byte. A match on the 25th verify still succeeds. A mismatch on the 25th verify stops the run with fail set and the failing-address output equal to that address, and no later address is pulsed.
- R7: After the last address, the program supply turns off. Every address from start to end is read in ascending order with chip enable and output enable low, first with supply select 10 (raised check), then with supply select 11 (lowered check), each address for the same fixed number of cycles.
- R8: A mismatch during either check pass sets fail, latches that address on the failing-address output and ends the run at once. No further reads take place, and a failure in the first pass means the second pass never starts.
- R9: A run that passes everything pulses done for exactly one cycle and leaves fail low. At the end of any run the pins return to the R1 resting values. Fail stays high until the next start.
- R10: A start asserted while a run is busy is ignored. The run in progress keeps its original address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (sampled when idle) |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range |
| src_addr | output | ADDR_W | Address whose target byte is requested |
| src_data | input | DATA_W | Target byte for src_addr |
| rom_addr | output | ADDR_W | Memory address pins |
| rom_dq_out | output | DATA_W | Byte driven onto memory data pins |
| rom_dq_oe | output | 1 | Data pin drive enable |
| rom_dq_in | input | DATA_W | Byte read from memory data pins |
| rom_ce_n | output | 1 | Memory chip enable, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| vpp_hi | output | 1 | Program supply on |
| vcc_sel | output | 2 | Core supply select: 00 nominal, 01 program, 10 raised check, 11 lowered check |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on a clean finish |
| fail | output | 1 | Run stopped on a failure |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The 25th verify of a byte carries two decisions in one cycle: it may be the match that advances the address, and it is also the one where the retry limit is reached. One byte is given a cell model that needs exactly 25 pulses and must finish cleanly, and another needs 30 pulses and must stop with its address after exactly 25. A second coincidence occurs at the last address of the first check pass, where the range end and the switch to the lowered supply fall together. A byte that reads wrong only at the lowered supply shows whether the pass switch and the failure latch line up, judged by how many read cycles the bench counts at each supply level.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_VERIFY,
    ST_REST,
    ST_SETTLE,
    ST_CHECK
  } seq_state_e;

  typedef enum logic [1:0] {
    SUP_NOM    = 2'b00,
    SUP_PROG   = 2'b01,
    SUP_CHK_HI = 2'b10,
    SUP_CHK_LO = 2'b11
  } supply_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len - W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TMR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) load |-> (len != '0)); // R3

endmodule

// File: rtl/eprom_seq_tries.sv
module eprom_seq_tries #(
  parameter int MAX = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == W'(MAX - 1));

  AST_TRIES_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) inc |-> !last); // R6
  AST_TRIES_CLR_INC_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(clr && inc)); // R6

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int MAX_TRIES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_dq_out,
  output logic              rom_dq_oe,
  input  logic [DATA_W-1:0] rom_dq_in,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              vpp_hi,
  output logic [1:0]        vcc_sel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  // Phase lengths in cycles
  localparam int PULSE_CYC = CLK_HZ / 10_000;                 // 100 us
  localparam int GAP_CYC   = ceil_div(CLK_HZ, 500_000);       // 2 us
  localparam int RD_CYC    = ceil_div(CLK_HZ, 10_000_000) + 1; // 100 ns access plus capture
  localparam int TW        = $clog2(PULSE_CYC + 1);
  localparam logic [TW-1:0] PULSE_LEN = TW'(PULSE_CYC);
  localparam logic [TW-1:0] GAP_LEN   = TW'(GAP_CYC);
  localparam logic [TW-1:0] RD_LEN    = TW'(RD_CYC);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] first_q, first_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              pass_q, pass_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              done_q, done_d;

  logic              tmr_load;
  logic [TW-1:0]     tmr_len;
  logic              tmr_exp;
  logic              tries_clr;
  logic              tries_inc;
  logic              tries_last;
  logic              byte_ok;
  logic              at_end;

  eprom_seq_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  eprom_seq_tries #(.MAX(MAX_TRIES)) u_tries (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (tries_clr),
    .inc   (tries_inc),
    .last  (tries_last)
  );

  assign byte_ok = (rom_dq_in == src_data);
  assign at_end  = (addr_q == last_q);

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    first_d   = first_q;
    last_d    = last_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    faddr_d   = faddr_q;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_len   = GAP_LEN;
    tries_clr = 1'b0;
    tries_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          addr_d    = start_addr;
          first_d   = start_addr;
          last_d    = end_addr;
          pass_d    = 1'b0;
          fail_d    = 1'b0;
          tries_clr = 1'b1;
          tmr_load  = 1'b1;
          st_d      = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = PULSE_LEN;
          st_d     = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          st_d     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          st_d     = ST_TURN;
        end
      end
      ST_TURN: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = RD_LEN;
          st_d     = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (tmr_exp) begin
          if (byte_ok) begin
            tries_clr = 1'b1;
            tmr_load  = 1'b1;
            if (at_end) begin
              addr_d = first_q;
              pass_d = 1'b0;
              st_d   = ST_SETTLE;
            end else begin
              addr_d = addr_q + ADDR_W'(1);
              st_d   = ST_REST;
            end
          end else if (tries_last) begin
            fail_d  = 1'b1;
            faddr_d = addr_q;
            st_d    = ST_IDLE;
          end else begin
            tries_inc = 1'b1;
            tmr_load  = 1'b1;
            st_d      = ST_REST;
          end
        end
      end
      ST_REST: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          st_d     = ST_SETUP;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_len  = RD_LEN;
          st_d     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (tmr_exp) begin
          if (!byte_ok) begin
            fail_d  = 1'b1;
            faddr_d = addr_q;
            st_d    = ST_IDLE;
          end else if (at_end) begin
            if (!pass_q) begin
              pass_d   = 1'b1;
              addr_d   = first_q;
              tmr_load = 1'b1;
              st_d     = ST_SETTLE;
            end else begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end else begin
            addr_d   = addr_q + ADDR_W'(1);
            tmr_load = 1'b1;
            tmr_len  = RD_LEN;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      first_q <= first_d;
      last_q  <= last_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
      done_q  <= done_d;
    end
  end

  // Pin decode from the registered state
  logic    prog_phase;
  supply_e sup;

  assign prog_phase = (st_q inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_TURN, ST_VERIFY, ST_REST});

  always_comb begin
    if (prog_phase) begin
      sup = SUP_PROG;
    end else if (st_q inside {ST_SETTLE, ST_CHECK}) begin
      sup = pass_q ? SUP_CHK_LO : SUP_CHK_HI;
    end else begin
      sup = SUP_NOM;
    end
  end

  assign rom_ce_n   = !(st_q inside {ST_PULSE, ST_CHECK});
  assign rom_oe_n   = !(st_q inside {ST_VERIFY, ST_CHECK});
  assign rom_dq_oe  = (st_q inside {ST_SETUP, ST_PULSE, ST_HOLD});
  assign rom_dq_out = src_data;
  assign rom_addr   = addr_q;
  assign src_addr   = addr_q;
  assign vpp_hi     = prog_phase;
  assign vcc_sel    = sup;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign fail       = fail_q;
  assign fail_addr  = faddr_q;

  // Pulse-width observer for the checks below
  logic [TW:0] pw_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pw_q <= '0;
    end else if (!rom_ce_n && vpp_hi) begin
      pw_q <= pw_q + (TW+1)'(1);
    end else begin
      pw_q <= '0;
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_sn) rom_dq_oe |-> rom_oe_n); // R4
  AST_PULSE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_sn) (!rom_ce_n && rom_dq_oe) |-> (vpp_hi && vcc_sel == SUP_PROG)); // R2
  AST_PULSE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_sn) (!rom_ce_n && vpp_hi) |-> (rom_oe_n && rom_dq_oe)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_sn) (rom_ce_n && pw_q != '0) |-> (pw_q == (TW+1)'(PULSE_CYC))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn) done |=> !done); // R9
  AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_sn) done |-> !fail); // R9
  AST_FAIL_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_sn) $rose(fail) |-> (fail_addr == $past(rom_addr))); // R6
  AST_CHECK_NO_VPP: assert property (@(posedge clk) disable iff (!rst_sn) (!rom_ce_n && !rom_oe_n) |-> !vpp_hi); // R7

endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 1_000_000;
  localparam int AW         = 4;
  localparam int DW         = 8;
  localparam int TRIES      = 25;
  localparam int NB         = 1 << AW;
  localparam int PULSE_CYC  = HZ / 10_000;
  localparam int GAP        = (HZ + 499_999) / 500_000;
  localparam int RD         = (HZ + 9_999_999) / 10_000_000 + 1;
  localparam int WD         = 60_000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] start_addr, end_addr;
  logic [AW-1:0] src_addr;
  logic [DW-1:0] src_data;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_dq_out, rom_dq_in;
  logic          rom_dq_oe, rom_ce_n, rom_oe_n, vpp_hi, busy, done, fail;
  logic [1:0]    vcc_sel;
  logic [AW-1:0] fail_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_prog_seq #(.CLK_HZ(HZ), .ADDR_W(AW), .DATA_W(DW), .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_addr(src_addr), .src_data(src_data), .rom_addr(rom_addr), .rom_dq_out(rom_dq_out),
    .rom_dq_oe(rom_dq_oe), .rom_dq_in(rom_dq_in), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .vpp_hi(vpp_hi), .vcc_sel(vcc_sel), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  // Byte source: never 0xFF, so an erased cell always mismatches
  assign src_data = {src_addr, 4'h3};

  // Memory cell model
  logic [DW-1:0] mem [NB];
  int            need [NB];
  int            pulses [NB];
  bit            weak_hi [NB];
  bit            weak_lo [NB];
  bit            erase_req;
  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = mem[rom_addr];
    if (!vpp_hi && ((vcc_sel == 2'b10 && weak_hi[rom_addr]) || (vcc_sel == 2'b11 && weak_lo[rom_addr])))
      rd_val = rd_val ^ 8'h01;
    rom_dq_in = rom_oe_n ? 8'h00 : rd_val;
  end

  int total, bad;
  int cyc, stab, pw, rise_cyc, dq_fall;
  int viol2, viol3, viol4, cyc_hi, cyc_lo, ord_bad, done_cnt;
  bit hold_armed, chg, rd_now;
  logic          p_ce, p_oe, p_dq, p_vpp, p_rd;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dout;

  always @(negedge clk) begin
    if (erase_req) begin
      for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; pulses[i] = 0; end
      viol2 = 0; viol3 = 0; viol4 = 0; cyc_hi = 0; cyc_lo = 0; ord_bad = 0; done_cnt = 0;
      hold_armed = 0;
    end else if (rst_n) begin
      cyc++;
      chg  = (rom_addr != p_addr) || (rom_dq_out != p_dout) || (rom_dq_oe != p_dq);
      stab = chg ? 1 : stab + 1;
      if (chg && hold_armed) begin
        if (cyc - rise_cyc < GAP) viol4++;
        hold_armed = 0;
      end
      if (!p_ce && rom_ce_n && p_vpp) begin
        if (pw != PULSE_CYC || pw < 95 || pw > 105) viol3++;
        pulses[rom_addr]++;
        if (pulses[rom_addr] >= need[rom_addr]) mem[rom_addr] = mem[rom_addr] & rom_dq_out;
        rise_cyc = cyc; hold_armed = 1;
      end
      if (!rom_ce_n && vpp_hi) begin
        if (p_ce) begin
          pw = 1;
          if (stab - 1 < GAP) viol4++;
        end else pw++;
        if (vcc_sel != 2'b01) viol2++;
        if (!rom_oe_n || !rom_dq_oe) viol3++;
      end
      if (p_dq && !rom_dq_oe) dq_fall = cyc;
      if (p_oe && !rom_oe_n && vpp_hi && (cyc - dq_fall < GAP)) viol4++;
      if (!rom_oe_n && rom_dq_oe) viol4++;
      if (vpp_hi && vcc_sel != 2'b01) viol2++;
      rd_now = !rom_ce_n && !rom_oe_n && !vpp_hi;
      if (rd_now) begin
        if (vcc_sel == 2'b10) cyc_hi++;
        else if (vcc_sel == 2'b11) cyc_lo++;
        else ord_bad++;
        if (p_rd && rom_addr != p_addr && rom_addr != p_addr + AW'(1)) ord_bad++;
      end
      if (done) done_cnt++;
    end
    p_ce = rom_ce_n; p_oe = rom_oe_n; p_dq = rom_dq_oe; p_vpp = vpp_hi;
    p_addr = rom_addr; p_dout = rom_dq_out; p_rd = rd_now;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_pins(input string tag);
    check(rom_ce_n == 1'b1 && rom_oe_n == 1'b1 && rom_dq_oe == 1'b0, tag, "control pins idle",
          {rom_ce_n, rom_oe_n, rom_dq_oe}, 3'b110);
    check(vpp_hi == 1'b0 && vcc_sel == 2'b00 && busy == 1'b0, tag, "supplies nominal, not busy",
          {vpp_hi, vcc_sel, busy}, 0);
  endtask

  // stuck < 0: no programming failure expected
  task automatic run(input int sa, input int ea, input bit exp_fail, input int exp_fa,
                     input int stuck, input int hi_reads, input int lo_reads, input bit mid_start);
    int  n;
    bit  seen;
    int  e;
    logic [DW-1:0] em;
    erase_req = 1'b1;
    @(negedge clk); @(negedge clk);
    erase_req = 1'b0;
    start_addr = AW'(sa); end_addr = AW'(ea); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; seen = 0;
    while (!seen && !fail && n < WD) begin
      @(negedge clk);
      n++;
      if (done) seen = 1;
      if (mid_start && n == 300) begin start_addr = 4'd2; end_addr = 4'd3; start = 1'b1; end
      if (mid_start && n == 301) start = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(n < WD, "R9", "watchdog", n, WD);
    check(fail == exp_fail, exp_fail ? "R6" : "R9", "fail flag", fail, exp_fail);
    if (exp_fail) check(fail_addr == AW'(exp_fa), stuck >= 0 ? "R6" : "R8", "failing address", fail_addr, exp_fa);
    check(done_cnt == (exp_fail ? 0 : 1), "R9", "done pulse cycles", done_cnt, exp_fail ? 0 : 1);
    for (int a = 0; a < NB; a++) begin
      if (a < sa || a > ea || (stuck >= 0 && a > stuck)) e = 0;
      else if (a == stuck) e = TRIES;
      else e = need[a];
      check(pulses[a] == e, (a == stuck) ? "R6" : "R5", $sformatf("pulses at %0d", a), pulses[a], e);
      em = (e != 0 && a != stuck) ? {AW'(a), 4'h3} : 8'hFF;
      check(mem[a] == em, "R5", $sformatf("cell at %0d", a), mem[a], em);
    end
    check(cyc_hi == hi_reads * RD, exp_fail ? "R8" : "R7", "raised-supply read cycles", cyc_hi, hi_reads * RD);
    check(cyc_lo == lo_reads * RD, exp_fail ? "R8" : "R7", "lowered-supply read cycles", cyc_lo, lo_reads * RD);
    check(ord_bad == 0, "R7", "check read order/supply", ord_bad, 0);
    check(viol2 == 0, "R2", "programming supply", viol2, 0);
    check(viol3 == 0, "R3", "pulse width/levels", viol3, 0);
    check(viol4 == 0, "R4", "setup/hold/turnaround", viol4, 0);
    idle_pins("R9");
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; stab = 0; pw = 0; rise_cyc = 0; dq_fall = 0;
    start = 1'b0; start_addr = '0; end_addr = '0; erase_req = 1'b0;
    for (int i = 0; i < NB; i++) begin need[i] = 1; weak_hi[i] = 0; weak_lo[i] = 0; mem[i] = 8'hFF; pulses[i] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    idle_pins("R1");
    check(done == 1'b0 && fail == 1'b0, "R1", "done/fail in reset", {done, fail}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_pins("R1");
    check(done == 1'b0 && fail == 1'b0, "R1", "done/fail after reset", {done, fail}, 0);

    // Full range, varied pulse needs, stray start mid-run (R10)
    for (int i = 0; i < NB; i++) need[i] = (i % 5) + 1;
    run(0, 15, 0, 0, -1, 16, 16, 1);
    check(cyc_hi == 16 * RD && pulses[15] == need[15], "R10", "stray start ignored", cyc_hi, 16 * RD);

    // Byte that never programs within the cap
    for (int i = 0; i < NB; i++) need[i] = 2;
    need[5] = 30;
    run(3, 7, 1, 5, 5, 0, 0, 0);

    // Match on exactly the 25th verify
    need[6] = 25;
    run(6, 6, 0, 0, -1, 1, 1, 0);

    // Weak at the lowered check supply
    for (int i = 0; i < NB; i++) need[i] = 1;
    weak_lo[10] = 1;
    run(8, 12, 1, 10, -1, 5, 3, 0);
    weak_lo[10] = 0;

    // Weak at the raised check supply: second pass never starts
    for (int i = 0; i < NB; i++) need[i] = 3;
    weak_hi[1] = 1;
    run(0, 3, 1, 1, -1, 2, 0, 0);
    weak_hi[1] = 0;

    // Top of the address space, fail cleared by the new start
    for (int i = 0; i < NB; i++) need[i] = (i & 1) ? 24 : 1;
    run(12, 15, 0, 0, -1, 4, 4, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule